// File: doc/BRIEF.md
# Multi-Mode Pin Port Controller

This block controls a port of 32 pins from a 32-bit register interface. Four configuration bits per pin place the pin in one of three modes. It can be an interrupt source, a general-purpose I/O, or a route to one of four alternate peripheral functions. The same bits carry a different meaning in each mode: trigger type and polarity, direction and output value, or the function number. Every configuration register can be read at one address. It also has a write-1-to-set address and a write-1-to-clear address, so software can change single pins without a read-modify-write sequence.

Pin inputs pass through a two-stage synchronizer. The synchronized levels can be read back at any time, and they feed a level or edge detector for each pin. Detected conditions latch into a pending-flag register. One combined interrupt line is raised while any flag of an enabled interrupt pin is set. The block drives output value and output enable for each pin, a 2-bit alternate-function select with a routing indication, and one pull enable for each pin.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After synchronous reset every pin is a GPIO input. The irq-mode register reads 0, the gate register all ones, the pattern-high register all ones, the pattern-low register 0, the pull-off register 0 and the flags 0. `pad_oe` and `irq_out` are 0 and `pull_en` is all ones.
- R2: The bus address is {sel[2:0], op[1:0]}. The sel values are 0 irq-mode, 1 gate, 2 pattern-high, 3 pattern-low, 4 pull-off, 5 pin level (read only) and 6 flag. op 1 sets the bits that are 1 in the write data, and op 2 clears them. Other bits keep their value, and op 0 writes do nothing. A read returns the register of that sel on `bus_rdata` one clock after `bus_rd`.
- R3: A pin with irq-mode=1 is an interrupt source. It has `pad_oe`=0 and `alt_en`=0.
- R4: A pin with irq-mode=0 and gate=1 is a GPIO. With pattern-high=1 it is an input (`pad_oe`=0). With pattern-high=0 it drives `pad_out` = pattern-low with `pad_oe`=1.
- R5: A pin with irq-mode=0 and gate=0 has `alt_en`=1 and `alt_sel[2n+1:2n]` = {pattern-high, pattern-low}, with `pad_oe`=0.
- R6: The pin-level register (sel 5) returns each input after a two-flop synchronizer, whatever the pin's mode.
- R7: Level trigger (pattern-high=0) sets the flag on every cycle the synchronized input equals pattern-low. A set wins over a flag clear (sel 6, op 2) in the same cycle, so clearing takes effect only once the input is inactive.
- R8: Edge trigger (pattern-high=1) sets the flag only on a rising edge (pattern-low=1) or a falling edge (pattern-low=0) of the synchronized input. A steady level does not set it again after a clear.
- R9: `irq_out` is 1 exactly while a flag is set on a pin with irq-mode=1 and gate=0. Flags of pins with gate=1 still latch.
- R10: A pin not in interrupt mode never sets its flag.
- R11: `pull_en[n]` is the inverse of pull-off bit n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 5 | {register select, operation} |
| bus_wdata | input | 32 | Write data, one bit per pin |
| bus_rdata | output | 32 | Read data, registered |
| pad_in | input | 32 | Asynchronous pin inputs |
| pad_out | output | 32 | Pin output values |
| pad_oe | output | 32 | Pin output enables |
| alt_en | output | 32 | Pin routed to an alternate function |
| alt_sel | output | 64 | Alternate function number, 2 bits per pin |
| pull_en | output | 32 | Pull resistor enable per pin |
| irq_out | output | 1 | Combined interrupt |

## Verification
The assertions assume that reset is held for at least one clock before any bus access, and that the flag clear strobe is qualified only by the decoded bus write. They also assume that `pad_in` reaches the detectors only through the synchronizer, so each edge check compares two registered samples. The stimulus changes `pad_in` and the bus signals only on the falling clock edge. It holds each pin level for several cycles so that every transition passes both synchronizer stages. It clears the flags after each reprogramming, so that transient codes written during configuration never leak into a later check.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    typedef enum logic [2:0] {
        SEL_IRQ   = 3'd0,
        SEL_GATE  = 3'd1,
        SEL_PHI   = 3'd2,
        SEL_PLO   = 3'd3,
        SEL_PULL  = 3'd4,
        SEL_LEVEL = 3'd5,
        SEL_FLAG  = 3'd6,
        SEL_NONE  = 3'd7
    } reg_sel_e;

    typedef enum logic [1:0] {
        OP_READ = 2'd0,
        OP_SET  = 2'd1,
        OP_CLR  = 2'd2,
        OP_RSVD = 2'd3
    } reg_op_e;

    typedef enum logic [1:0] {
        PM_ALT  = 2'd0,
        PM_GPIO = 2'd1,
        PM_IRQ  = 2'd2
    } pin_mode_e;

    typedef struct packed {
        logic irq;
        logic gate;
        logic phi;
        logic plo;
    } pin_cfg_t;

    localparam int unsigned CFG_REGS = 5;

    function automatic pin_mode_e decode_mode(input pin_cfg_t c);
        if (c.irq)       return PM_IRQ;
        else if (c.gate) return PM_GPIO;
        else             return PM_ALT;
    endfunction

    // Per-bit reset value of configuration register idx: gate and pattern-high start at one
    function automatic logic cfg_reset_bit(input int idx);
        return (idx == int'(SEL_GATE)) || (idx == int'(SEL_PHI));
    endfunction

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH  = 32,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    logic [WIDTH-1:0] stage_q [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                stage_q[s] <= '0;
            else if (s == 0)
                stage_q[s] <= async_in;
            else
                stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
        end
    end

    assign sync_out = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_mode_decode.sv
module gpio_mode_decode
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS = 32
) (
    input  logic [PINS-1:0]   cfg_irq,
    input  logic [PINS-1:0]   cfg_gate,
    input  logic [PINS-1:0]   cfg_phi,
    input  logic [PINS-1:0]   cfg_plo,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   alt_en,
    output logic [2*PINS-1:0] alt_sel
);
    for (genvar i = 0; i < PINS; i++) begin : g_pin
        pin_cfg_t  cfg;
        pin_mode_e mode;
        assign cfg  = '{irq: cfg_irq[i], gate: cfg_gate[i], phi: cfg_phi[i], plo: cfg_plo[i]};
        assign mode = decode_mode(cfg);

        always_comb begin
            pad_out[i]        = 1'b0;
            pad_oe[i]         = 1'b0;
            alt_en[i]         = 1'b0;
            alt_sel[2*i +: 2] = 2'b00;
            case (mode)
                PM_GPIO: begin
                    pad_oe[i]  = ~cfg.phi;
                    pad_out[i] = ~cfg.phi & cfg.plo;
                end
                PM_ALT: begin
                    alt_en[i]         = 1'b1;
                    alt_sel[2*i +: 2] = {cfg.phi, cfg.plo};
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit #(
    parameter int unsigned PINS = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [PINS-1:0] level,
    input  logic [PINS-1:0] cfg_irq,
    input  logic [PINS-1:0] cfg_gate,
    input  logic [PINS-1:0] cfg_phi,
    input  logic [PINS-1:0] cfg_plo,
    input  logic            clr_valid,
    input  logic [PINS-1:0] clr_mask,
    output logic [PINS-1:0] flag,
    output logic            irq_out
);
    logic [PINS-1:0] prev_q;
    logic [PINS-1:0] rise, fall, edge_hit, lvl_hit, set_hit, clr_bits;

    assign rise     = level & ~prev_q;
    assign fall     = ~level & prev_q;
    assign edge_hit = (rise & cfg_plo) | (fall & ~cfg_plo);
    assign lvl_hit  = ~(level ^ cfg_plo);
    assign set_hit  = cfg_irq & ((cfg_phi & edge_hit) | (~cfg_phi & lvl_hit));
    assign clr_bits = clr_valid ? clr_mask : '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q <= '0;
            flag   <= '0;
        end else begin
            prev_q <= level;
            flag   <= (flag & ~clr_bits) | set_hit;
        end
    end

    assign irq_out = |(flag & cfg_irq & ~cfg_gate);

    AST_FLAG_NEEDS_IRQ_MODE: assert property (@(posedge clk) disable iff (rst)
        ((flag & ~$past(flag) & ~$past(cfg_irq)) == '0)); // R10
    AST_EDGE_NEEDS_TRANSITION: assert property (@(posedge clk) disable iff (rst)
        ((flag & ~$past(flag) & $past(cfg_irq & cfg_phi) & ~$past(level ^ prev_q)) == '0)); // R8
    AST_CLEAR_UNLESS_SET: assert property (@(posedge clk) disable iff (rst)
        clr_valid |=> ((flag & $past(clr_mask) & ~$past(set_hit)) == '0)); // R7
    AST_IRQ_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
        irq_out |-> (|flag)); // R9
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int unsigned PINS = 32,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [4:0]        bus_addr,
    input  logic [PINS-1:0]   bus_wdata,
    output logic [PINS-1:0]   bus_rdata,
    input  logic [PINS-1:0]   pad_in,
    output logic [PINS-1:0]   pad_out,
    output logic [PINS-1:0]   pad_oe,
    output logic [PINS-1:0]   alt_en,
    output logic [2*PINS-1:0] alt_sel,
    output logic [PINS-1:0]   pull_en,
    output logic              irq_out
);
    reg_sel_e        sel;
    reg_op_e         op;
    logic [PINS-1:0] cfg_q [CFG_REGS];
    logic [PINS-1:0] level;
    logic [PINS-1:0] flag;
    logic            flag_clr;

    assign sel = reg_sel_e'(bus_addr[4:2]);
    assign op  = reg_op_e'(bus_addr[1:0]);

    for (genvar r = 0; r < CFG_REGS; r++) begin : g_cfg
        logic hit;
        assign hit = bus_wr && (int'(sel) == r);
        always_ff @(posedge clk) begin
            if (rst)
                cfg_q[r] <= {PINS{cfg_reset_bit(r)}};
            else if (hit && op == OP_SET)
                cfg_q[r] <= cfg_q[r] | bus_wdata;
            else if (hit && op == OP_CLR)
                cfg_q[r] <= cfg_q[r] & ~bus_wdata;
        end
    end

    assign flag_clr = bus_wr && sel == SEL_FLAG && op == OP_CLR;

    always_ff @(posedge clk) begin
        if (rst)
            bus_rdata <= '0;
        else if (bus_rd) begin
            case (sel)
                SEL_IRQ:   bus_rdata <= cfg_q[0];
                SEL_GATE:  bus_rdata <= cfg_q[1];
                SEL_PHI:   bus_rdata <= cfg_q[2];
                SEL_PLO:   bus_rdata <= cfg_q[3];
                SEL_PULL:  bus_rdata <= cfg_q[4];
                SEL_LEVEL: bus_rdata <= level;
                SEL_FLAG:  bus_rdata <= flag;
                default:   bus_rdata <= '0;
            endcase
        end
    end

    gpio_sync #(.WIDTH(PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (pad_in),
        .sync_out (level)
    );

    gpio_mode_decode #(.PINS(PINS)) u_decode (
        .cfg_irq  (cfg_q[0]),
        .cfg_gate (cfg_q[1]),
        .cfg_phi  (cfg_q[2]),
        .cfg_plo  (cfg_q[3]),
        .pad_out  (pad_out),
        .pad_oe   (pad_oe),
        .alt_en   (alt_en),
        .alt_sel  (alt_sel)
    );

    gpio_irq_unit #(.PINS(PINS)) u_irq (
        .clk       (clk),
        .rst       (rst),
        .level     (level),
        .cfg_irq   (cfg_q[0]),
        .cfg_gate  (cfg_q[1]),
        .cfg_phi   (cfg_q[2]),
        .cfg_plo   (cfg_q[3]),
        .clr_valid (flag_clr),
        .clr_mask  (bus_wdata),
        .flag      (flag),
        .irq_out   (irq_out)
    );

    assign pull_en = ~cfg_q[4];

    AST_SET_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_PLO && op == OP_SET) |=> ((cfg_q[3] & $past(bus_wdata)) == $past(bus_wdata))); // R2
    AST_CLR_ALIAS: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && sel == SEL_PHI && op == OP_CLR) |=> ((cfg_q[2] & $past(bus_wdata)) == '0)); // R2
    AST_NO_DRIVE_IN_IRQ: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & cfg_q[0]) == '0)); // R3
    AST_ALT_NOT_DRIVEN: assert property (@(posedge clk) disable iff (rst)
        ((pad_oe & alt_en) == '0)); // R5
endmodule

// File: tb/gpio_port_ctrl_bench.sv
module gpio_port_ctrl_bench;
    localparam int PINS = 32;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              bus_wr = 1'b0;
    logic              bus_rd = 1'b0;
    logic [4:0]        bus_addr = '0;
    logic [PINS-1:0]   bus_wdata = '0;
    logic [PINS-1:0]   bus_rdata;
    logic [PINS-1:0]   pad_in = '0;
    logic [PINS-1:0]   pad_out, pad_oe, alt_en, pull_en;
    logic [2*PINS-1:0] alt_sel;
    logic              irq_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 0;

    always #2ns clk = ~clk;

    gpio_port_ctrl u_gpio_port_ctrl (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pad_in(pad_in), .pad_out(pad_out),
        .pad_oe(pad_oe), .alt_en(alt_en), .alt_sel(alt_sel), .pull_en(pull_en), .irq_out(irq_out)
    );

    // {code = irq,gate,phi,plo ; oe ; out ; alt_en ; alt_sel}
    localparam logic [8:0] MODE_VEC [8] = '{
        9'b1001_0_0_0_00,
        9'b0000_0_0_1_00,
        9'b0001_0_0_1_01,
        9'b0010_0_0_1_10,
        9'b0011_0_0_1_11,
        9'b0100_1_0_0_00,
        9'b0101_1_1_0_00,
        9'b0110_0_0_0_00
    };

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [1:0] op, input logic [PINS-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = {sel, op}; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0; bus_wdata = '0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [PINS-1:0] v);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = {sel, 2'd0};
        @(negedge clk);
        bus_rd = 1'b0;
        v = bus_rdata;
    endtask

    task automatic program_pin(input int p, input logic [3:0] code);
        for (int b = 0; b < 4; b++)
            wr(3'(b), code[3-b] ? 2'd1 : 2'd2, PINS'(1) << p);
    endtask

    task automatic wait_cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(4ns * 100000);
        n_checks++; n_fail++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        logic [PINS-1:0] v;
        wait_cycles(3);
        rst = 1'b0;
        wait_cycles(1);

        // R1 reset state
        rd(3'd0, v); check("R1 irq", v, 0);
        rd(3'd1, v); check("R1 gate", v, 32'hFFFF_FFFF);
        rd(3'd2, v); check("R1 phi", v, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R1 plo", v, 0);
        rd(3'd6, v); check("R1 flag", v, 0);
        check("R1 oe", pad_oe, 0);
        check("R1 pull", pull_en, 32'hFFFF_FFFF);
        check("R1 irq_out", irq_out, 0);

        // R2 set/clear aliases
        wr(3'd3, 2'd1, 32'h0000_00F0);
        wr(3'd3, 2'd2, 32'h0000_0030);
        wr(3'd3, 2'd0, 32'hFFFF_FFFF);
        rd(3'd3, v); check("R2 set/clear", v, 32'h0000_00C0);
        wr(3'd3, 2'd2, 32'hFFFF_FFFF);

        // R11 pull
        wr(3'd4, 2'd1, 32'h0000_0004);
        check("R11 pull_en", pull_en, 32'hFFFF_FFFB);

        // R6 pin level
        pad_in = 32'hA5A5_0F0F;
        wait_cycles(3);
        rd(3'd5, v); check("R6 level", v, 32'hA5A5_0F0F);
        pad_in = '0;
        wait_cycles(3);

        // R3 R4 R5 mode table on pin 20
        for (int k = 0; k < 8; k++) begin
            program_pin(20, MODE_VEC[k][8:5]);
            check("R3/R4/R5 decode",
                  {pad_oe[20], pad_out[20], alt_en[20], alt_sel[41:40]},
                  MODE_VEC[k][4:0]);
        end

        // R7 level-high on pin 3
        program_pin(3, 4'b1001);
        wr(3'd6, 2'd2, 32'hFFFF_FFFF);
        rd(3'd6, v); check("R7 no flag while low", v, 0);
        pad_in[3] = 1'b1;
        wait_cycles(4);
        check("R7/R9 irq_out", irq_out, 1);
        rd(3'd5, v); check("R6 level in irq mode", v[3], 1);
        wr(3'd6, 2'd2, 32'h0000_0008);
        rd(3'd6, v); check("R7 set wins over clear", v, 32'h0000_0008);
        // R9 mask
        wr(3'd1, 2'd1, 32'h0000_0008);
        check("R9 masked irq_out", irq_out, 0);
        rd(3'd6, v); check("R9 masked flag latches", v, 32'h0000_0008);
        wr(3'd1, 2'd2, 32'h0000_0008);
        check("R9 unmasked irq_out", irq_out, 1);
        pad_in[3] = 1'b0;
        wait_cycles(3);
        wr(3'd6, 2'd2, 32'h0000_0008);
        rd(3'd6, v); check("R7 clear when inactive", v, 0);
        check("R9 irq_out low", irq_out, 0);

        // R8 rising edge on pin 7
        program_pin(7, 4'b1011);
        wr(3'd6, 2'd2, 32'hFFFF_FFFF);
        pad_in[7] = 1'b1;
        wait_cycles(4);
        rd(3'd6, v); check("R8 rising sets", v, 32'h0000_0080);
        wr(3'd6, 2'd2, 32'h0000_0080);
        wait_cycles(3);
        rd(3'd6, v); check("R8 steady high no retrigger", v, 0);

        // R8 falling edge on pin 8
        pad_in[8] = 1'b1;
        program_pin(8, 4'b1010);
        wait_cycles(3);
        wr(3'd6, 2'd2, 32'hFFFF_FFFF);
        rd(3'd6, v); check("R8 high no fall flag", v, 0);
        pad_in[8] = 1'b0;
        wait_cycles(4);
        rd(3'd6, v); check("R8 falling sets", v, 32'h0000_0100);
        wr(3'd6, 2'd2, 32'hFFFF_FFFF);

        // R10 GPIO input pin 10 toggles
        pad_in[10] = 1'b1; wait_cycles(4);
        pad_in[10] = 1'b0; wait_cycles(4);
        rd(3'd6, v); check("R10 non-irq pin flag", v[10], 0);

        summary();
    end
endmodule